// File: doc/BRIEF.md
# Triggered Queue Command Arbiter

This block sits in front of one on-chip converter and decides which of several command queues may feed its command input. Each queue shows the arbiter its head command word, whether it is empty, a trigger event strobe, a gate level and a mode bit that selects edge triggering or level (gated) triggering. The arbiter keeps one "triggered" flag per queue. Each cycle it forms the set of eligible queues: the queue must be triggered, must not be empty and must hold a head command whose destination bits name this converter. In level mode the gate must also be open.

When the converter raises its ready input and an eligible queue exists, the lowest-index eligible queue wins. Its head word is forwarded and its pop strobe pulses in the same cycle. Command fields decide when a queue's run finishes. An end-of-queue flag drops the triggered state in either mode. A pause flag does the same in edge mode only. In level mode a closed gate stops the run at once. Arbitration happens on every command, so a higher-priority queue that becomes triggered takes the very next accepted command, and the interrupted queue stays triggered and resumes after it.

Top module: `tq_cmd_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `trig_o`, `pop_o` and `cmd_vld_o` are all zero.
- R2: In edge mode (`level_mode_i[q]`=0), a one-cycle high on `trig_evt_i[q]` sets `trig_o[q]` after the next rising clock edge. If the same edge also carries a clearing condition, the set wins.
- R3: A queue is eligible only if its head word has bit 26 = 0 (internal destination) and bit 25 = 0 (buffer 0). A triggered queue whose head names another destination sends nothing and does not block lower-priority queues.
- R4: A triggered queue with `empty_i[q]`=1 is never popped and does not block lower-priority queues.
- R5: Among eligible queues, index 0 has the highest priority. `cmd_o` equals the winner's head word. `pop_o` is one-hot on the winner in any cycle where `cmd_rdy_i`=1.
- R6: When no queue is eligible, `cmd_vld_o`=0 and `pop_o`=0, whatever the value of `cmd_rdy_i`.
- R7: Once a command with bit 31 (end of queue) set has been popped, that queue's `trig_o` bit is zero after the edge. This holds in both modes.
- R8: Once a command with bit 30 (pause) set has been popped, `trig_o` clears for a queue in edge mode. For a queue in level mode the pause bit has no effect.
- R9: In level mode, a rising `gate_i[q]` sets `trig_o[q]` after the next edge. A low `gate_i[q]` makes the queue ineligible in that same cycle and clears `trig_o[q]` after the next edge.
- R10: A higher-priority queue that becomes triggered wins the next accepted command. The lower queue keeps its `trig_o` bit and resumes once the higher queue's run has ended.
- R11: While `cmd_rdy_i`=0 no pop occurs and no `trig_o` bit clears through a command's flags. `cmd_vld_o` and `cmd_o` still show the current winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| head_cmd_i | input | NUM_Q x CMD_W | Head command word of each queue |
| empty_i | input | NUM_Q | Queue has no command |
| trig_evt_i | input | NUM_Q | Trigger event strobe (edge mode) |
| level_mode_i | input | NUM_Q | 1 = level (gated) mode, 0 = edge mode |
| gate_i | input | NUM_Q | Gate level (level mode) |
| cmd_rdy_i | input | 1 | Converter accepts a command this cycle |
| cmd_vld_o | output | 1 | An eligible command is presented |
| cmd_o | output | CMD_W | Winning head command word |
| pop_o | output | NUM_Q | Pop strobe to the winning queue, same cycle as accept |
| trig_o | output | NUM_Q | Per-queue triggered state |

## Verification
The winner, `cmd_o`, `cmd_vld_o` and `pop_o` are combinational from the inputs and `trig_o`. They are due in the same cycle as the stimulus, so the bench drives just after a falling edge and samples 1 ns later. Any change to `trig_o` comes from one register and appears after the next rising edge, so each trigger, gate, end-of-queue or pause effect is checked after the following falling edge. Eligibility is checked by sweeping all 64 combinations of eligible queues under a mix of empty and wrong-destination blockers, alternating the ready input. Directed sequences then cover run termination, gating and preemption.

// File: rtl/tq_arb_pkg.sv
package tq_arb_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;

  typedef struct packed {
    logic eoq;
    logic pause;
    logic ext;
    logic bnum;
  } cmd_flags_t;
endpackage

// File: rtl/tq_dest_match.sv
module tq_dest_match #(
  parameter int NUM_Q = 6,
  parameter bit MY_EB = 1'b0,
  parameter bit MY_BN = 1'b0
) (
  input  tq_arb_pkg::cmd_flags_t [NUM_Q-1:0] flags_i,
  output logic [NUM_Q-1:0]                   hit_o
);
  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    assign hit_o[q] = (flags_i[q].ext == MY_EB) && (flags_i[q].bnum == MY_BN);
  end
endmodule

// File: rtl/tq_trig_track.sv
module tq_trig_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic evt_i,
  input  logic gate_i,
  input  logic pop_i,
  input  logic eoq_i,
  input  logic pause_i,
  output logic trig_o,
  output logic run_ok_o
);
  import tq_arb_pkg::*;

  logic gate_q, trig_q, set, clr, lvl;

  assign lvl = (trig_mode_e'(mode_i) == TRIG_LEVEL);
  assign set = lvl ? (gate_i & ~gate_q) : evt_i;
  // run terminators; pause only counts in edge mode
  assign clr = (pop_i & eoq_i)
             | (~lvl & pop_i & pause_i)
             | (lvl & ~gate_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      gate_q <= gate_i;
      trig_q <= set | (trig_q & ~clr);
    end
  end

  assign trig_o   = trig_q;
  assign run_ok_o = trig_q & (~lvl | gate_i);

  a_r7_eoq_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && eoq_i && !set) |=> !trig_q);
  a_r2_edge_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && evt_i) |=> trig_q);
  a_r8_edge_pause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && pop_i && pause_i && !evt_i) |=> !trig_q);
  a_r9_gate_low_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !gate_i) |=> !trig_q);
endmodule

// File: rtl/tq_prio_pick.sv
module tq_prio_pick #(
  parameter int NUM_Q = 6,
  localparam int IDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic [NUM_Q-1:0] req_i,
  output logic [NUM_Q-1:0] gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  logic [NUM_Q:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_chain
    assign gnt_o[q]       = req_i[q] & ~blocked[q];
    assign blocked[q + 1] = blocked[q] | req_i[q];
  end

  assign any_o = blocked[NUM_Q];

  always_comb begin
    idx_o = '0;
    for (int q = NUM_Q - 1; q >= 0; q--) begin
      if (req_i[q]) idx_o = IDX_W'(q);
    end
  end
endmodule

// File: rtl/tq_cmd_arbiter.sv
module tq_cmd_arbiter #(
  parameter int NUM_Q     = 6,
  parameter int CMD_W     = 32,
  parameter int EOQ_BIT   = 31,
  parameter int PAUSE_BIT = 30,
  parameter int EB_BIT    = 26,
  parameter int BN_BIT    = 25,
  parameter bit MY_EB     = 1'b0,
  parameter bit MY_BN     = 1'b0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_Q-1:0][CMD_W-1:0] head_cmd_i,
  input  logic [NUM_Q-1:0]            empty_i,
  input  logic [NUM_Q-1:0]            trig_evt_i,
  input  logic [NUM_Q-1:0]            level_mode_i,
  input  logic [NUM_Q-1:0]            gate_i,
  input  logic                        cmd_rdy_i,
  output logic                        cmd_vld_o,
  output logic [CMD_W-1:0]            cmd_o,
  output logic [NUM_Q-1:0]            pop_o,
  output logic [NUM_Q-1:0]            trig_o
);
  import tq_arb_pkg::*;

  localparam int IDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

  cmd_flags_t [NUM_Q-1:0] flags;
  logic [NUM_Q-1:0] dest_hit, run_ok, elig, gnt;
  logic [IDX_W-1:0] win_idx;
  logic             any_elig;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_flags
    assign flags[q].eoq   = head_cmd_i[q][EOQ_BIT];
    assign flags[q].pause = head_cmd_i[q][PAUSE_BIT];
    assign flags[q].ext   = head_cmd_i[q][EB_BIT];
    assign flags[q].bnum  = head_cmd_i[q][BN_BIT];
  end

  tq_dest_match #(.NUM_Q(NUM_Q), .MY_EB(MY_EB), .MY_BN(MY_BN)) u_dest (
    .flags_i (flags),
    .hit_o   (dest_hit)
  );

  for (genvar q = 0; q < NUM_Q; q++) begin : g_trk
    tq_trig_track u_trk (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mode_i   (level_mode_i[q]),
      .evt_i    (trig_evt_i[q]),
      .gate_i   (gate_i[q]),
      .pop_i    (pop_o[q]),
      .eoq_i    (flags[q].eoq),
      .pause_i  (flags[q].pause),
      .trig_o   (trig_o[q]),
      .run_ok_o (run_ok[q])
    );
  end

  // empty or foreign-destination queues drop out and never block
  assign elig = run_ok & ~empty_i & dest_hit;

  tq_prio_pick #(.NUM_Q(NUM_Q)) u_pick (
    .req_i (elig),
    .gnt_o (gnt),
    .idx_o (win_idx),
    .any_o (any_elig)
  );

  assign cmd_vld_o = any_elig;
  assign cmd_o     = head_cmd_i[win_idx];
  assign pop_o     = cmd_rdy_i ? gnt : '0;

  a_r5_pop_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pop_o));
  a_r11_no_pop_unready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_rdy_i |-> (pop_o == '0));
  a_r4_empty_never_pops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o & empty_i) == '0);
  a_r6_pop_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o != '0) |-> cmd_vld_o);
  a_r9_closed_gate_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o & level_mode_i & ~gate_i) == '0);
  a_r3_pop_only_own_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o != '0) |-> (cmd_o[EB_BIT] == MY_EB && cmd_o[BN_BIT] == MY_BN));
endmodule

// File: tb/tq_cmd_arbiter_bench.sv
module tq_cmd_arbiter_bench;
  localparam int NQ = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [NQ-1:0][31:0] head_cmd_i;
  logic [NQ-1:0] empty_i, trig_evt_i, level_mode_i, gate_i;
  logic cmd_rdy_i;
  logic cmd_vld_o;
  logic [31:0] cmd_o;
  logic [NQ-1:0] pop_o, trig_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  tq_cmd_arbiter u_tq_cmd_arbiter (
    .clk_i(clk_i), .rst_ni(rst_ni), .head_cmd_i(head_cmd_i), .empty_i(empty_i),
    .trig_evt_i(trig_evt_i), .level_mode_i(level_mode_i), .gate_i(gate_i),
    .cmd_rdy_i(cmd_rdy_i), .cmd_vld_o(cmd_vld_o), .cmd_o(cmd_o),
    .pop_o(pop_o), .trig_o(trig_o)
  );

  function automatic logic [31:0] mk(bit eoq, bit pz, bit eb, bit bn, logic [7:0] tag);
    return {eoq, pz, 3'b000, eb, bn, 17'd0, tag};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic idle_inputs();
    for (int q = 0; q < NQ; q++) head_cmd_i[q] = mk(0, 0, 0, 0, 8'(q));
    empty_i = '1; trig_evt_i = '0; level_mode_i = '0; gate_i = '0; cmd_rdy_i = 1'b0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_ni = 1'b0;
    step(); step();
    rst_ni = 1'b1;
    settle();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    step(); settle();
    // R1: reset state
    chk(trig_o == 0 && cmd_vld_o == 0 && pop_o == 0, "R1 reset", {trig_o, pop_o, 7'(cmd_vld_o)}, 0);
    do_reset();
    chk(trig_o == 0 && cmd_vld_o == 0, "R1 after reset", {trig_o, 7'(cmd_vld_o)}, 0);

    // R6: nothing triggered, all ready -> idle
    empty_i = '0; cmd_rdy_i = 1'b1; settle();
    chk(cmd_vld_o == 0 && pop_o == 0, "R6 none eligible", {pop_o, 7'(cmd_vld_o)}, 0);

    // R2: trigger every queue in edge mode
    trig_evt_i = '1; settle();
    chk(trig_o == 0, "R2 not before edge", trig_o, 0);
    step(); trig_evt_i = '0; cmd_rdy_i = 1'b0; settle();
    chk(trig_o == 6'h3f, "R2 edge trigger", trig_o, 6'h3f);

    // R3 R4 R5 R6: sweep all eligible subsets
    for (int p = 0; p < 64; p++) begin
      int win;
      bit rdy;
      win = -1;
      for (int q = NQ - 1; q >= 0; q--) if (p[q]) win = q;
      rdy = (p % 3) != 0;
      for (int q = 0; q < NQ; q++) begin
        if (p[q]) begin
          head_cmd_i[q] = mk(0, 0, 0, 0, 8'(8'h10 + q)); empty_i[q] = 1'b0;
        end else if (q % 2 == 0) begin
          head_cmd_i[q] = mk(0, 0, 0, 0, 8'(8'h10 + q)); empty_i[q] = 1'b1;
        end else begin
          head_cmd_i[q] = mk(0, 0, (q % 4) == 1, (q % 4) == 3, 8'(8'h10 + q)); empty_i[q] = 1'b0;
        end
      end
      cmd_rdy_i = rdy; settle();
      if (win < 0) begin
        chk(cmd_vld_o == 0 && pop_o == 0, "R6 sweep idle", {pop_o, 7'(cmd_vld_o)}, 0);
      end else begin
        chk(cmd_vld_o == 1, "R5 sweep valid", cmd_vld_o, 1);
        chk(cmd_o == mk(0, 0, 0, 0, 8'(8'h10 + win)), "R3 R4 R5 sweep winner word", cmd_o, mk(0, 0, 0, 0, 8'(8'h10 + win)));
        chk(pop_o == (rdy ? 6'(1 << win) : 6'd0), "R5 sweep pop", pop_o, rdy ? 6'(1 << win) : 6'd0);
      end
      step();
    end
    settle();
    chk(trig_o == 6'h3f, "R5 sweep keeps triggers", trig_o, 6'h3f);

    // R7: end of queue drops trigger
    do_reset();
    trig_evt_i[2] = 1'b1; step(); trig_evt_i = '0;
    head_cmd_i[2] = mk(1, 0, 0, 0, 8'h22); empty_i[2] = 1'b0; cmd_rdy_i = 1'b1; settle();
    chk(pop_o == 6'b000100, "R7 eoq popped", pop_o, 6'b000100);
    step(); settle();
    chk(trig_o[2] == 0 && cmd_vld_o == 0, "R7 eoq clears", {trig_o, 7'(cmd_vld_o)}, 0);

    // R11: not ready holds state and shows winner
    do_reset();
    trig_evt_i[3] = 1'b1; step(); trig_evt_i = '0;
    head_cmd_i[3] = mk(1, 0, 0, 0, 8'h33); empty_i[3] = 1'b0; cmd_rdy_i = 1'b0; settle();
    chk(pop_o == 0 && cmd_vld_o == 1 && cmd_o == mk(1, 0, 0, 0, 8'h33), "R11 not ready", {pop_o, cmd_o}, {6'd0, mk(1, 0, 0, 0, 8'h33)});
    step(); step(); settle();
    chk(trig_o == 6'b001000, "R11 trigger held", trig_o, 6'b001000);

    // R8: pause in edge mode ends run
    head_cmd_i[3] = mk(0, 1, 0, 0, 8'h34); cmd_rdy_i = 1'b1; settle();
    chk(pop_o == 6'b001000, "R8 pause popped", pop_o, 6'b001000);
    step(); settle();
    chk(trig_o == 0, "R8 edge pause clears", trig_o, 0);

    // R8: pause ignored in level mode
    do_reset();
    level_mode_i[4] = 1'b1; gate_i[4] = 1'b1;
    head_cmd_i[4] = mk(0, 1, 0, 0, 8'h44); empty_i[4] = 1'b0; cmd_rdy_i = 1'b1;
    step(); step(); step(); settle();
    chk(trig_o == 6'b010000 && pop_o == 6'b010000, "R8 level pause ignored", {trig_o, pop_o}, {6'b010000, 6'b010000});

    // R9: level gating
    do_reset();
    level_mode_i[5] = 1'b1; head_cmd_i[5] = mk(0, 0, 0, 0, 8'h55); empty_i[5] = 1'b0;
    step(); gate_i[5] = 1'b1; settle();
    chk(trig_o == 0 && cmd_vld_o == 0, "R9 gate rise not yet", {trig_o, 7'(cmd_vld_o)}, 0);
    step(); settle();
    chk(trig_o == 6'b100000 && cmd_vld_o == 1, "R9 gate open triggers", {trig_o, 7'(cmd_vld_o)}, {6'b100000, 7'd1});
    gate_i[5] = 1'b0; cmd_rdy_i = 1'b1; settle();
    chk(cmd_vld_o == 0 && pop_o == 0, "R9 closed gate same cycle", {pop_o, 7'(cmd_vld_o)}, 0);
    step(); settle();
    chk(trig_o == 0, "R9 closed gate clears", trig_o, 0);

    // R10: preemption and resume
    do_reset();
    trig_evt_i[3] = 1'b1; step(); trig_evt_i = '0;
    head_cmd_i[3] = mk(0, 0, 0, 0, 8'h3a); empty_i[3] = 1'b0;
    head_cmd_i[1] = mk(0, 0, 0, 0, 8'h1a); empty_i[1] = 1'b0; cmd_rdy_i = 1'b1; settle();
    chk(pop_o == 6'b001000, "R10 untriggered higher does not block", pop_o, 6'b001000);
    trig_evt_i[1] = 1'b1; settle();
    chk(pop_o == 6'b001000, "R10 low still sends in trigger cycle", pop_o, 6'b001000);
    step(); trig_evt_i = '0; settle();
    chk(pop_o == 6'b000010 && cmd_o == mk(0, 0, 0, 0, 8'h1a), "R10 higher preempts", {pop_o, cmd_o}, {6'b000010, mk(0, 0, 0, 0, 8'h1a)});
    chk(trig_o == 6'b001010, "R10 lower stays triggered", trig_o, 6'b001010);
    head_cmd_i[1] = mk(1, 0, 0, 0, 8'h1b); step(); settle();
    chk(trig_o == 6'b001000 && pop_o == 6'b001000, "R10 lower resumes", {trig_o, pop_o}, {6'b001000, 6'b001000});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule